// File: doc/BRIEF.md
# RMII Receive Di-bit Deserializer

This block sits on the MAC side of a reduced media-independent receive interface. It samples the carrier/data-valid line, the 2-bit receive data and the receive error line on the 50 MHz reference clock, then rebuilds bytes from the di-bits and presents them on a simple byte stream. Each byte comes out on a one-cycle valid pulse, with start-of-frame and end-of-frame markers and an error flag.

Once carrier/data-valid rises, the block ignores the 00 filler di-bits that the PHY sends before decoding settles. It locks onto the first non-zero di-bit and follows the preamble until the start-frame delimiter. It then packs the frame data into bytes, lowest di-bit first. While carrier/data-valid is low, the receive data is ignored whatever its value. A speed input selects between 100 Mbps, where every clock carries a di-bit, and 10 Mbps, where each di-bit is held for ten clocks. In 10 Mbps mode the block samples once per di-bit, with the phase taken from the first non-zero di-bit.

The last complete byte of a frame is held back until the frame ends, so that the end-of-frame marker rides on a real byte.

Top module: `rmii_rx_deser`

## Requirements
- R1: After reset, out_valid, out_sof, out_eof and out_err are all low.
- R2: After crs_dv rises, di-bits of 00 received before the first non-zero di-bit are discarded as filler, whether there are none or several.
- R3: While crs_dv is low, any rxd value (00, 01, 10 or 11) produces no output and does not disturb the next frame.
- R4: A frame starts with preamble di-bits 01 and ends its delimiter with di-bit 11 (byte 0xD5 sent lowest pair first: 01,01,01,11). If a di-bit of 00 or 10 arrives before that 11, the frame is dropped with no output.
- R5: Data di-bits are packed lowest pair first. The first di-bit after the delimiter goes to out_data[1:0] and the fourth goes to out_data[7:6].
- R6: Every complete data byte is emitted exactly once on a one-cycle out_valid pulse. out_sof is high only with the first byte of a frame and out_eof only with the last.
- R7: The first low sample of crs_dv ends the frame. The held last byte is then emitted with out_eof within three clocks.
- R8: If the frame ends with 1 to 3 data di-bits left over after the last whole byte, out_err is high with out_eof and the leftover di-bits are dropped.
- R9: If rx_er is high in any cycle while crs_dv is high, out_err is high with that frame's out_eof.
- R10: With speed_fast low, one di-bit is taken every 10 clocks, starting at the first non-zero di-bit. A frame whose di-bits are each held 10 clocks decodes to the same bytes as in fast mode.
- R11: A frame that ends before one complete data byte follows the delimiter produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crs_dv | input | 1 | Carrier sense / receive data valid |
| rxd | input | 2 | Receive di-bit |
| rx_er | input | 1 | Receive error from the PHY |
| speed_fast | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| out_valid | output | 1 | One-cycle byte strobe |
| out_data | output | 8 | Received byte |
| out_sof | output | 1 | First byte of the frame |
| out_eof | output | 1 | Last byte of the frame |
| out_err | output | 1 | Frame error, valid with out_eof |

## Verification
On every cycle the assertions check several properties. No di-bit is taken while the registered carrier is low. Two di-bits are never taken on back-to-back clocks in 10 Mbps mode. Every plain byte strobe follows a data di-bit, and the frame markers and error flag only appear on a valid byte. Other behaviour only shows up over whole frames, so the bench scenarios carry it. Those scenarios cover the byte values and their pair order, filler skipping, dropping after a bad preamble, leftover di-bits, error propagation, and decoding at 10 Mbps.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREAM,
    ST_DATA,
    ST_DROP
  } rx_state_e;

  localparam logic [1:0] DIBIT_PRE = 2'b01;
  localparam logic [1:0] DIBIT_SFD = 2'b11;
endpackage

// File: rtl/rmii_rx_sampler.sv
module rmii_rx_sampler #(
  parameter int SLOW_DIV = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crs_dv,
  input  logic [1:0] rxd,
  input  logic       rx_er,
  input  logic       fast,
  output logic       crs_q,
  output logic       er_q,
  output logic       stb,
  output logic [1:0] dibit
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [1:0]    rxd_q;
  logic          locked_q, locked_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          stb_c;

  // input capture register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_q <= 1'b0;
      rxd_q <= 2'b00;
      er_q  <= 1'b0;
    end else begin
      crs_q <= crs_dv;
      rxd_q <= rxd;
      er_q  <= rx_er;
    end
  end

  // take a di-bit: hunt for first non-zero, then every clock or every SLOW_DIV clocks
  always_comb begin
    if (!crs_q)
      stb_c = 1'b0;
    else if (!locked_q)
      stb_c = (rxd_q != 2'b00);
    else
      stb_c = fast || (cnt_q == '0);
  end

  always_comb begin
    locked_n = locked_q;
    cnt_n    = cnt_q;
    if (!crs_q) begin
      locked_n = 1'b0;
      cnt_n    = '0;
    end else if (stb_c) begin
      locked_n = 1'b1;
      cnt_n    = CW'(SLOW_DIV - 1);
    end else if (locked_q && (cnt_q != '0)) begin
      cnt_n    = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      locked_q <= locked_n;
      cnt_q    <= cnt_n;
    end
  end

  assign stb   = stb_c;
  assign dibit = rxd_q;
endmodule

// File: rtl/rmii_rx_delim.sv
module rmii_rx_delim
  import rmii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crs_q,
  input  logic       er_q,
  input  logic       stb,
  input  logic [1:0] dibit,
  output logic       in_data,
  output logic       data_stb,
  output logic       frame_end,
  output logic       frame_err
);
  rx_state_e state_q, state_n;
  logic      er_seen_q, er_seen_n;

  always_comb begin
    state_n = state_q;
    if (!crs_q) begin
      state_n = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE, ST_PREAM: begin
          if (stb) begin
            if (dibit == DIBIT_SFD)      state_n = ST_DATA;
            else if (dibit == DIBIT_PRE) state_n = ST_PREAM;
            else                         state_n = ST_DROP;
          end else begin
            state_n = ST_PREAM;
          end
        end
        ST_DATA: state_n = ST_DATA;
        default: state_n = ST_DROP;
      endcase
    end
  end

  always_comb begin
    er_seen_n = crs_q ? (er_seen_q | er_q) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      er_seen_q <= 1'b0;
    end else begin
      state_q   <= state_n;
      er_seen_q <= er_seen_n;
    end
  end

  assign in_data   = (state_q == ST_DATA);
  assign data_stb  = in_data && stb;
  assign frame_end = in_data && !crs_q;
  assign frame_err = er_seen_q;
endmodule

// File: rtl/rmii_rx_packer.sv
module rmii_rx_packer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_data,
  input  logic              data_stb,
  input  logic [1:0]        dibit,
  input  logic              frame_end,
  input  logic              frame_err,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_err
);
  localparam int PAIRS = BYTE_W / 2;
  localparam int PCW   = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [PCW-1:0]    pair_q, pair_n;
  logic [BYTE_W-3:0] acc_q, acc_n;
  logic              pend_v_q, pend_v_n;
  logic [BYTE_W-1:0] pend_d_q, pend_d_n;
  logic              pend_sof_q, pend_sof_n;
  logic              first_q, first_n;
  logic              ov_q, ov_n, os_q, os_n, oe_q, oe_n, oer_q, oer_n;
  logic [BYTE_W-1:0] od_q, od_n;
  logic [BYTE_W-1:0] word;

  assign word = {dibit, acc_q};

  always_comb begin
    pair_n     = pair_q;
    acc_n      = acc_q;
    pend_v_n   = pend_v_q;
    pend_d_n   = pend_d_q;
    pend_sof_n = pend_sof_q;
    first_n    = first_q;
    ov_n       = 1'b0;
    os_n       = 1'b0;
    oe_n       = 1'b0;
    oer_n      = 1'b0;
    od_n       = od_q;
    if (frame_end) begin
      if (pend_v_q) begin
        ov_n  = 1'b1;
        od_n  = pend_d_q;
        os_n  = pend_sof_q;
        oe_n  = 1'b1;
        oer_n = frame_err || (pair_q != '0);
      end
      pend_v_n = 1'b0;
      pair_n   = '0;
      first_n  = 1'b1;
    end else if (!in_data) begin
      pend_v_n = 1'b0;
      pair_n   = '0;
      first_n  = 1'b1;
    end else if (data_stb) begin
      acc_n = word[BYTE_W-1:2];
      if (pair_q == PCW'(PAIRS - 1)) begin
        pair_n = '0;
        if (pend_v_q) begin
          ov_n = 1'b1;
          od_n = pend_d_q;
          os_n = pend_sof_q;
        end
        pend_v_n   = 1'b1;
        pend_d_n   = word;
        pend_sof_n = first_q;
        first_n    = 1'b0;
      end else begin
        pair_n = pair_q + PCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q     <= '0;
      acc_q      <= '0;
      pend_v_q   <= 1'b0;
      pend_d_q   <= '0;
      pend_sof_q <= 1'b0;
      first_q    <= 1'b1;
      ov_q       <= 1'b0;
      os_q       <= 1'b0;
      oe_q       <= 1'b0;
      oer_q      <= 1'b0;
      od_q       <= '0;
    end else begin
      pair_q     <= pair_n;
      acc_q      <= acc_n;
      pend_v_q   <= pend_v_n;
      pend_d_q   <= pend_d_n;
      pend_sof_q <= pend_sof_n;
      first_q    <= first_n;
      ov_q       <= ov_n;
      os_q       <= os_n;
      oe_q       <= oe_n;
      oer_q      <= oer_n;
      od_q       <= od_n;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_sof   = os_q;
  assign out_eof   = oe_q;
  assign out_err   = oer_q;
endmodule

// File: rtl/rmii_rx_deser.sv
module rmii_rx_deser #(
  parameter int SLOW_DIV = 10,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crs_dv,
  input  logic [1:0]        rxd,
  input  logic              rx_er,
  input  logic              speed_fast,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_err
);
  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic       crs_q, er_q, dibit_stb, in_data, data_stb, frame_end, frame_err;
  logic [1:0] dibit;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  rmii_rx_sampler #(.SLOW_DIV(SLOW_DIV)) u_samp (
    .clk(clk), .rst_n(rst_i), .crs_dv(crs_dv), .rxd(rxd), .rx_er(rx_er),
    .fast(speed_fast), .crs_q(crs_q), .er_q(er_q), .stb(dibit_stb), .dibit(dibit)
  );

  rmii_rx_delim u_delim (
    .clk(clk), .rst_n(rst_i), .crs_q(crs_q), .er_q(er_q), .stb(dibit_stb),
    .dibit(dibit), .in_data(in_data), .data_stb(data_stb),
    .frame_end(frame_end), .frame_err(frame_err)
  );

  rmii_rx_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_i), .in_data(in_data), .data_stb(data_stb),
    .dibit(dibit), .frame_end(frame_end), .frame_err(frame_err),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_err(out_err)
  );
endmodule

// File: rtl/rmii_rx_chk.sv
module rmii_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic crs_q,
  input logic stb,
  input logic in_data,
  input logic fast,
  input logic out_valid,
  input logic out_sof,
  input logic out_eof,
  input logic out_err
);
  p_idle_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !crs_q |-> !stb);

  p_byte_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |-> $past(stb && in_data));

  p_sof_on_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  p_eof_on_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);

  p_err_with_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_eof);

  p_slow_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast && stb) |=> !stb);
endmodule

bind rmii_rx_deser rmii_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .crs_q(crs_q), .stb(dibit_stb), .in_data(in_data),
  .fast(speed_fast), .out_valid(out_valid), .out_sof(out_sof),
  .out_eof(out_eof), .out_err(out_err)
);

// File: tb/rmii_rx_deser_test.sv
`timescale 1ns/1ps
module rmii_rx_deser_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       crs_dv, rx_er, speed_fast;
  logic [1:0] rxd;
  logic       out_valid, out_sof, out_eof, out_err;
  logic [7:0] out_data;

  int ncheck = 0;
  int nfail  = 0;
  int rn     = 0;
  logic [7:0] rd [0:63];
  logic [2:0] rf [0:63];

  always #2.5 clk = ~clk;

  rmii_rx_deser uut (
    .clk(clk), .rst_n(rst_n), .crs_dv(crs_dv), .rxd(rxd), .rx_er(rx_er),
    .speed_fast(speed_fast), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      if (rn < 64) begin
        rd[rn] = out_data;
        rf[rn] = {out_sof, out_eof, out_err};
      end
      rn = rn + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ncheck++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int len);
    return 8'(i * 37 + len * 11 + 90);
  endfunction

  task automatic drive(input logic c, input logic [1:0] d, input logic e, input int n);
    crs_dv = c; rxd = d; rx_er = e;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input bit fast, input int nfill, input int len, input int extra,
                      input int er_pos, input logic [1:0] idle_rxd);
    int hold;
    logic [7:0] b;
    hold = fast ? 1 : 10;
    speed_fast = fast;
    rn = 0;
    for (int i = 0; i < nfill; i++) drive(1'b1, 2'b00, 1'b0, hold);
    for (int i = 0; i < 31; i++) drive(1'b1, 2'b01, 1'b0, hold);
    drive(1'b1, 2'b11, 1'b0, hold);
    for (int i = 0; i < len; i++) begin
      b = pat(i, len);
      for (int k = 0; k < 4; k++)
        drive(1'b1, b[2*k +: 2], (i * 4 + k) == er_pos, hold);
    end
    for (int e = 0; e < extra; e++) drive(1'b1, 2'(e + 1), 1'b0, hold);
    drive(1'b0, idle_rxd, 1'b0, 40);
    rxd = 2'b00;
  endtask

  task automatic verify(input int len, input bit exp_err, input string tag);
    logic [2:0] ef;
    chk(rn == len, {tag, " byte count"}, rn, len);
    for (int i = 0; i < len && i < rn; i++) begin
      chk(rd[i] == pat(i, len), {tag, " R5 data"}, rd[i], pat(i, len));
      ef = {i == 0, i == len - 1, (i == len - 1) && exp_err};
      chk(rf[i] == ef, {tag, " R6 R7 sof/eof/err"}, rf[i], ef);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    ncheck++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", ncheck - nfail, ncheck);
    $finish;
  end

  initial begin
    rst_n = 1'b0; crs_dv = 1'b0; rxd = 2'b00; rx_er = 1'b0; speed_fast = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet outputs after reset
    chk({out_valid, out_sof, out_eof, out_err} == 4'b0, "R1 reset outputs",
        {out_valid, out_sof, out_eof, out_err}, 0);

    // R3: garbage while carrier low
    rn = 0;
    drive(1'b0, 2'b01, 1'b0, 10);
    drive(1'b0, 2'b11, 1'b0, 10);
    drive(1'b0, 2'b10, 1'b0, 10);
    drive(1'b0, 2'b00, 1'b0, 10);
    chk(rn == 0, "R3 idle rxd ignored", rn, 0);

    // R2 R5 R6 R7 R11: fast sweep over length and filler count
    for (int len = 0; len <= 8; len++)
      for (int nf = 0; nf <= 3; nf++) begin
        send(1'b1, nf, len, 0, -1, 2'(nf));
        verify(len, 1'b0, (len == 0) ? "R11 R2" : "R2");
      end

    // R8: leftover di-bits, with non-zero idle rxd afterwards (R3)
    for (int len = 0; len <= 5; len++)
      for (int ex = 1; ex <= 3; ex++) begin
        send(1'b1, 2, len, ex, -1, 2'b11);
        verify(len, 1'b1, (len == 0) ? "R8 R11 R3" : "R8 R3");
      end

    // R9: receive error during the frame
    send(1'b1, 1, 4, 0, 5, 2'b00);
    verify(4, 1'b1, "R9");
    send(1'b1, 0, 1, 0, 3, 2'b00);
    verify(1, 1'b1, "R9 last dibit");

    // R4: bad preamble di-bit drops the frame
    rn = 0;
    speed_fast = 1'b1;
    for (int i = 0; i < 6; i++) drive(1'b1, 2'b01, 1'b0, 1);
    drive(1'b1, 2'b10, 1'b0, 1);
    for (int i = 0; i < 24; i++) drive(1'b1, 2'b01, 1'b0, 1);
    drive(1'b1, 2'b11, 1'b0, 1);
    for (int i = 0; i < 8; i++) drive(1'b1, 2'(i), 1'b0, 1);
    drive(1'b0, 2'b00, 1'b0, 40);
    chk(rn == 0, "R4 bad preamble dropped", rn, 0);
    send(1'b1, 0, 2, 0, -1, 2'b00);
    verify(2, 1'b0, "R4 recovery");

    // R10: 10 Mbps operation
    for (int len = 1; len <= 3; len++)
      for (int ex = 0; ex <= 2; ex += 2) begin
        send(1'b0, len - 1, len, ex, -1, 2'b00);
        verify(len, ex != 0, "R10 slow");
      end
    send(1'b0, 1, 2, 0, 6, 2'b01);
    verify(2, 1'b1, "R10 R9 slow err");

    $display("%0d/%0d checks passed", ncheck - nfail, ncheck);
    $finish;
  end
endmodule